// File: doc/BRIEF.md
# Prioritized Interrupt Status Arbiter

This block collects four interrupt events of a serial port and tells the host which one to service first. Each source condition is watched for a rising edge, and every edge leaves a pending flag behind. An enable mask chosen by the host selects which pending flags take part. The highest-priority enabled flag is reported as a 4-bit code. The interrupt line is asserted while any enabled flag is pending.

The host pulses a status-read strobe to fetch the report. On that clock edge the current code is captured into the output register, and only the flag it names is cleared. The remaining flags stay pending and appear on later reads, one per read in priority order. A write to the transmit holding register also clears the transmit-empty flag. The captured code does not change between reads, so the host always sees a stable value.

Top module: `isr_arbiter`

## Requirements
- R1: After reset, statusCode is 0001, irq is 0 and no event is pending.
- R2: A pending event is set on a rising edge of its source bit (srcLevel bit 0 line error, bit 1 receive data, bit 2 receive timeout, bit 3 transmit empty). A source held high does not set it again once it has been cleared.
- R3: A status read reports the highest-priority enabled pending event, with this order and these codes: line error 0110 ahead of receive data 0100, ahead of receive timeout 1100, ahead of transmit empty 0010.
- R4: A status read clears only the event it reports. The other events stay pending and are reported by later reads in priority order.
- R5: An event whose srcEnable bit is 0 is neither reported nor drives irq, but it stays pending. It takes part again as soon as its enable bit is set.
- R6: irq is 1 exactly when at least one enabled event is pending.
- R7: statusCode changes only on the clock edge where statusRd is high. Between reads it holds its value even when events arrive.
- R8: A status read with no enabled event pending returns 0001 and clears nothing.
- R9: A holdWrite pulse clears a pending transmit-empty event without a status read.
- R10: If a new rising edge of a source arrives in the same cycle as the read that clears that source, the event stays pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| srcLevel | input | 4 | Source conditions: bit 0 line error, 1 receive data, 2 timeout, 3 transmit empty |
| srcEnable | input | 4 | Per-source enable, same bit order |
| statusRd | input | 1 | Status read strobe, one cycle per read |
| holdWrite | input | 1 | Transmit holding register write strobe |
| statusCode | output | 4 | Captured status code, 0001 when nothing is pending |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: four sources and a 4-bit code. At these values every priority pairing and every code value can be reached with directed stimulus. All four events are raised together and then drained one read at a time, which shows the ordering and the clear of a single event per read. Masking, a holding-register write, and a new edge that arrives in the same cycle as the read that clears it are each checked in a scenario of their own.

// File: rtl/isr_pkg.sv
package isr_pkg;
  localparam int NSRC   = 4;
  localparam int CODE_W = 4;

  localparam int SRC_LINE = 0;
  localparam int SRC_RX   = 1;
  localparam int SRC_TMO  = 2;
  localparam int SRC_TX   = 3;

  localparam logic [CODE_W-1:0] CODE_NONE = 4'b0001;

  typedef struct packed {
    logic            capture;
    logic [NSRC-1:0] clrMask;
  } isr_strobe_t;

  function automatic logic [CODE_W-1:0] srcCode(input int idx);
    case (idx)
      SRC_LINE: srcCode = 4'b0110;
      SRC_RX:   srcCode = 4'b0100;
      SRC_TMO:  srcCode = 4'b1100;
      SRC_TX:   srcCode = 4'b0010;
      default:  srcCode = CODE_NONE;
    endcase
  endfunction
endpackage

// File: rtl/isr_ctrl.sv
module isr_ctrl
  import isr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            statusRd,
  input  logic            holdWrite,
  input  logic [NSRC-1:0] winner,
  output isr_strobe_t     strb
);
  logic [NSRC-1:0] txClr;

  always_comb begin
    txClr         = '0;
    txClr[SRC_TX] = holdWrite;
    strb.capture  = statusRd;
    strb.clrMask  = (statusRd ? winner : '0) | txClr;
  end

  // R3: the arbiter names at most one source
  assert_single_winner_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(winner));

  // R4: a read clears at most one source apart from the holding-write clear
  assert_one_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (statusRd && !holdWrite) |-> $countones(strb.clrMask) <= 1);
endmodule

// File: rtl/isr_dp.sv
module isr_dp
  import isr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   srcLevel,
  input  logic [NSRC-1:0]   srcEnable,
  input  isr_strobe_t       strb,
  output logic [NSRC-1:0]   winner,
  output logic [CODE_W-1:0] statusCode,
  output logic              irq
);
  logic [NSRC-1:0]   srcPrev;
  logic [NSRC-1:0]   pending;
  logic [NSRC-1:0]   riseEdge;
  logic [NSRC-1:0]   live;
  logic [CODE_W-1:0] codeNext;

  assign riseEdge = srcLevel & ~srcPrev;
  assign live     = pending & srcEnable;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        srcPrev[i] <= 1'b0;
        pending[i] <= 1'b0;
      end else begin
        srcPrev[i] <= srcLevel[i];
        pending[i] <= (pending[i] & ~strb.clrMask[i]) | riseEdge[i];
      end
    end

    // R4: an event that is not cleared stays pending
    assert_keep_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (pending[i] && !strb.clrMask[i]) |=> pending[i]);

    // R10: a new edge overrides a clear in the same cycle
    assert_edge_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      riseEdge[i] |=> pending[i]);
  end

  always_comb begin
    winner   = '0;
    codeNext = CODE_NONE;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (live[i]) begin
        winner   = '0;
        winner[i] = 1'b1;
        codeNext = srcCode(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            statusCode <= CODE_NONE;
    else if (strb.capture) statusCode <= codeNext;
  end

  assign irq = |live;

  // R7: the code holds between reads
  assert_code_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.capture |=> $stable(statusCode));

  // R8: a read with nothing enabled pending returns the idle code
  assert_idle_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.capture && !irq) |=> statusCode == CODE_NONE);

  // R6: the interrupt line agrees with the arbiter
  assert_irq_winner_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (winner != '0));
endmodule

// File: rtl/isr_arbiter.sv
module isr_arbiter
  import isr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   srcLevel,
  input  logic [NSRC-1:0]   srcEnable,
  input  logic              statusRd,
  input  logic              holdWrite,
  output logic [CODE_W-1:0] statusCode,
  output logic              irq
);
  isr_strobe_t     strb;
  logic [NSRC-1:0] winner;

  isr_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .statusRd  (statusRd),
    .holdWrite (holdWrite),
    .winner    (winner),
    .strb      (strb)
  );

  isr_dp u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .srcLevel   (srcLevel),
    .srcEnable  (srcEnable),
    .strb       (strb),
    .winner     (winner),
    .statusCode (statusCode),
    .irq        (irq)
  );
endmodule

// File: tb/isr_arbiter_tb.sv
module isr_arbiter_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] srcLevel = '0;
  logic [3:0] srcEnable = '0;
  logic       statusRd = 1'b0;
  logic       holdWrite = 1'b0;
  logic [3:0] statusCode;
  logic       irq;
  int checks = 0;
  int failures = 0;

  localparam logic [3:0] C_LINE = 4'b0110, C_RX = 4'b0100, C_TMO = 4'b1100,
                         C_TX = 4'b0010, C_NONE = 4'b0001;

  always #4 clk = ~clk;

  isr_arbiter u_dut (.clk(clk), .rst_n(rst_n), .srcLevel(srcLevel), .srcEnable(srcEnable),
                     .statusRd(statusRd), .holdWrite(holdWrite),
                     .statusCode(statusCode), .irq(irq));

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic readChk(input string req, input logic [3:0] exp);
    @(negedge clk) statusRd = 1'b1;
    @(negedge clk) statusRd = 1'b0;
    chk(req, statusCode, exp);
  endtask

  task automatic setSrc(input logic [3:0] v);
    @(negedge clk) srcLevel = v;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 code", statusCode, C_NONE);
    chk("R1 irq", {3'b0, irq}, 4'b0000);
    srcEnable = 4'hF;
    @(negedge clk);
    chk("R1 nothing pending", {3'b0, irq}, 4'b0000);
  endtask

  task automatic t_priority();
    setSrc(4'hF);
    chk("R6 irq set", {3'b0, irq}, 4'b0001);
    readChk("R3 line first", C_LINE);
    readChk("R4 rx next", C_RX);
    readChk("R4 timeout next", C_TMO);
    readChk("R4 tx last", C_TX);
    chk("R6 irq clear", {3'b0, irq}, 4'b0000);
    readChk("R8 empty read", C_NONE);
  endtask

  task automatic t_level();
    readChk("R2 held level no retrigger", C_NONE);
    setSrc(4'h0);
    setSrc(4'b0010);
    readChk("R2 new edge rx", C_RX);
  endtask

  task automatic t_mask();
    setSrc(4'h0);
    srcEnable = 4'b1110;
    setSrc(4'b1001);
    chk("R5 tx drives irq", {3'b0, irq}, 4'b0001);
    readChk("R5 masked line skipped", C_TX);
    chk("R5 masked no irq", {3'b0, irq}, 4'b0000);
    @(negedge clk) srcEnable = 4'hF;
    @(negedge clk);
    chk("R5 unmask irq", {3'b0, irq}, 4'b0001);
    readChk("R5 line kept pending", C_LINE);
  endtask

  task automatic t_stable();
    setSrc(4'h0);
    readChk("R8 idle", C_NONE);
    setSrc(4'b0100);
    chk("R6 timeout irq", {3'b0, irq}, 4'b0001);
    chk("R7 code held", statusCode, C_NONE);
    readChk("R7 timeout after read", C_TMO);
  endtask

  task automatic t_write();
    setSrc(4'h0);
    setSrc(4'b1000);
    chk("R9 tx irq", {3'b0, irq}, 4'b0001);
    @(negedge clk) holdWrite = 1'b1;
    @(negedge clk) holdWrite = 1'b0;
    chk("R9 write clears irq", {3'b0, irq}, 4'b0000);
    readChk("R9 nothing left", C_NONE);
  endtask

  task automatic t_collide();
    setSrc(4'b0010);
    @(negedge clk) srcLevel = 4'b0000;
    @(negedge clk) begin statusRd = 1'b1; srcLevel = 4'b0010; end
    @(negedge clk) statusRd = 1'b0;
    chk("R10 first read rx", statusCode, C_RX);
    chk("R10 irq stays", {3'b0, irq}, 4'b0001);
    readChk("R10 rx still pending", C_RX);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_priority();
        t_level();
        t_mask();
        t_stable();
        t_write();
        t_collide();
      end
      begin
        repeat (5000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule